// File: doc/BRIEF.md
# Shift and Rotate Group Execution Unit

This unit executes the two-operand shift and rotate instruction group of a 16-bit processor for register-direct operands. The issue stage presents the opcode byte, the ModR/M byte, an immediate count byte, the current CL value, the register operand, the carry flag and the overflow flag, all with a single valid strobe. One clock edge later the unit presents the shifted or rotated value with the new carry and overflow flags.

The opcode bits choose the count source and the operand size, and the middle field of the ModR/M byte chooses the operation and its direction. The operations are plain rotate, rotate through carry, logical shift and arithmetic shift. The field value 110, which assemblers never emit, is accepted and runs as a left shift rather than being rejected. Before use, the count is cut to its low five bits. Rotate through carry works on an operand that is one bit wider, with the carry flag as its top bit. A cut count of zero passes the operand and both flags through unchanged.

Top module: `shift_rotate_unit`

## Requirements
- R1: While `rst` is high at a clock edge, that edge clears `out_valid`, `result`, `carry_out` and `overflow_out` to 0.
- R2: A request with `in_valid` high at an edge produces its outputs after that same edge, with `out_valid` high for exactly one cycle. With no request, `out_valid` is low.
- R3: The count source is set by opcode bits. If bit 4 is 0, the count is `imm_count`. If bit 4 is 1 and bit 1 is 0, the count is 1. If bit 4 is 1 and bit 1 is 1, the count is `cl_value`.
- R4: Opcode bit 0 set to 1 selects a 16-bit operand. Set to 0, it selects `operand[7:0]`; `operand[15:8]` is then ignored and `result[15:8]` is 0.
- R5: `modrm[5:4]` selects the operation: 00 rotate, 01 rotate through carry, 10 logical shift, 11 arithmetic shift. `modrm[3]` = 1 means right and 0 means left. `modrm[7:6]` and `modrm[2:0]` have no effect.
- R6: The count is taken modulo 32, using its low 5 bits. A count of zero gives `result` equal to the operand at the selected size, `carry_out` = `carry_in` and `overflow_out` = `of_in`.
- R7: A rotate moves each bit that leaves one end in at the other end, and `carry_out` is the last bit moved. Rotate through carry works on {carry, operand}, which is 9 or 17 bits wide.
- R8: A logical shift fills with zeros. `carry_out` is the last bit shifted out, so with a count larger than the size both the result and `carry_out` are 0.
- R9: `modrm[5:3]` = 110 gives the same result and flags as 100, a left logical shift.
- R10: An arithmetic right shift fills with copies of the operand's sign bit, and `carry_out` is the last bit shifted out.
- R11: With a count of 1, `overflow_out` is as follows. For every left operation, it is 1 when the sign bit of the result differs from the sign bit of the operand. For a rotate right, it is the exclusive-or of the two top result bits. For a rotate right through carry, it is the operand sign bit exclusive-or `carry_in`. For a logical right shift, it is the operand sign bit. For an arithmetic right shift, it is 0.
- R12: With a count of 2 or more, `overflow_out` = `of_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 8 | Opcode byte (bits 4, 1, 0 decoded) |
| modrm | input | 8 | ModR/M byte (bits 5:3 decoded) |
| imm_count | input | 8 | Immediate count byte |
| cl_value | input | 8 | CL register value |
| operand | input | 16 | Register operand |
| carry_in | input | 1 | Current carry flag |
| of_in | input | 1 | Current overflow flag |
| out_valid | output | 1 | Result strobe |
| result | output | 16 | Shifted or rotated value |
| carry_out | output | 1 | New carry flag |
| overflow_out | output | 1 | New overflow flag |

## Verification
The bench aims at the counts where a wrong design tends to fail. Counts 32 and above must wrap to small values; a design that ignores the mask returns zero for such counts. A count of exactly the operand size must still leave the last bit in carry. Counts of 9 or 17 in rotate through carry must come back to the starting state; a design using modulo-size arithmetic would leave carry set wrong there. It also drives garbage in the upper operand byte in byte mode, conflicting immediate and CL values to catch a wrong count source, the 110 alias, which a strict decoder would reject or treat as a right shift, and single-bit counts where each operation has its own overflow rule.

// File: rtl/sru_pkg.sv
package sru_pkg;

  typedef enum logic [1:0] {
    OP_ROT  = 2'b00,
    OP_RCX  = 2'b01,
    OP_SHL  = 2'b10,
    OP_SAR  = 2'b11
  } sru_op_e;

  typedef struct packed {
    sru_op_e    op;
    logic       right;
    logic       wide;
    logic [4:0] count;
  } sru_cmd_t;

endpackage

// File: rtl/sru_decode.sv
module sru_decode
  import sru_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [7:0] opcode,
  input  logic [7:0] modrm,
  input  logic [7:0] imm_count,
  input  logic [7:0] cl_value,
  output sru_cmd_t   cmd
);
  logic [7:0] raw_cnt;
  logic       use_var;
  logic       use_cl;

  assign use_var = opcode[4];
  assign use_cl  = opcode[1];

  always_comb begin
    if (!use_var)     raw_cnt = imm_count;
    else if (use_cl)  raw_cnt = cl_value;
    else              raw_cnt = 8'd1;
  end

  always_comb begin
    cmd.op    = sru_op_e'(modrm[5:4]);
    cmd.right = modrm[3];
    cmd.wide  = opcode[0];
    cmd.count = raw_cnt[CNT_W-1:0];
  end
endmodule

// File: rtl/sru_shifter.sv
module sru_shifter
  import sru_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  sru_cmd_t           cmd,
  input  logic [DATA_W-1:0]  operand,
  input  logic               carry_in,
  output logic [DATA_W-1:0]  res,
  output logic               carry_res
);
  localparam int NARROW_W = DATA_W / 2;
  localparam int MAX_CNT  = (1 << CNT_W) - 1;

  logic [DATA_W-1:0] mask;
  int unsigned       msb;

  assign mask = cmd.wide ? {DATA_W{1'b1}} : {{NARROW_W{1'b0}}, {NARROW_W{1'b1}}};
  assign msb  = cmd.wide ? DATA_W - 1 : NARROW_W - 1;

  always_comb begin
    logic [DATA_W-1:0] v;
    logic              c;
    logic              fill;
    logic              out_bit;
    v = operand & mask;
    c = carry_in;
    for (int i = 0; i < MAX_CNT; i++) begin
      if (i < int'(cmd.count)) begin
        if (!cmd.right) begin
          out_bit = v[msb];
          case (cmd.op)
            OP_ROT:  fill = v[msb];
            OP_RCX:  fill = c;
            default: fill = 1'b0;
          endcase
          v = ((v << 1) | {{(DATA_W-1){1'b0}}, fill}) & mask;
        end else begin
          out_bit = v[0];
          case (cmd.op)
            OP_ROT:  fill = v[0];
            OP_RCX:  fill = c;
            OP_SAR:  fill = v[msb];
            default: fill = 1'b0;
          endcase
          v = v >> 1;
          v[msb] = fill;
        end
        c = out_bit;
      end
    end
    res       = v;
    carry_res = c;
  end
endmodule

// File: rtl/sru_flags.sv
module sru_flags
  import sru_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  sru_cmd_t          cmd,
  input  logic [DATA_W-1:0] res,
  input  logic              carry_res,
  input  logic              of_in,
  output logic              of_res
);
  localparam int NARROW_W = DATA_W / 2;

  logic top, next;

  assign top  = cmd.wide ? res[DATA_W-1] : res[NARROW_W-1];
  assign next = cmd.wide ? res[DATA_W-2] : res[NARROW_W-2];

  always_comb begin
    if (cmd.count == 5'd1) of_res = cmd.right ? (top ^ next) : (top ^ carry_res);
    else                   of_res = of_in;
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic [7:0]        modrm,
  input  logic [7:0]        imm_count,
  input  logic [7:0]        cl_value,
  input  logic [DATA_W-1:0] operand,
  input  logic              carry_in,
  input  logic              of_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              overflow_out
);
  localparam int NARROW_W = DATA_W / 2;

  sru_cmd_t          cmd;
  logic [DATA_W-1:0] nxt_res;
  logic              nxt_cf;
  logic              nxt_of;

  sru_decode #(.CNT_W(CNT_W)) u_dec (
    .opcode(opcode), .modrm(modrm), .imm_count(imm_count),
    .cl_value(cl_value), .cmd(cmd)
  );

  sru_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shf (
    .cmd(cmd), .operand(operand), .carry_in(carry_in),
    .res(nxt_res), .carry_res(nxt_cf)
  );

  sru_flags #(.DATA_W(DATA_W)) u_flg (
    .cmd(cmd), .res(nxt_res), .carry_res(nxt_cf), .of_in(of_in), .of_res(nxt_of)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      result       <= '0;
      carry_out    <= 1'b0;
      overflow_out <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result       <= nxt_res;
        carry_out    <= nxt_cf;
        overflow_out <= nxt_of;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!out_valid && result == '0));
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R4
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !opcode[0]) |=> result[DATA_W-1:NARROW_W] == '0);
  // R6
  zero_count_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode[0] && !opcode[4] && imm_count[CNT_W-1:0] == '0)
    |=> (result == $past(operand) && carry_out == $past(carry_in)
         && overflow_out == $past(of_in)));
  // R10
  sar_sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode[0] && modrm[5:3] == 3'b111) |=> result[DATA_W-1] == $past(operand[DATA_W-1]));
  // R11
  sar_single_of_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode[4] && !opcode[1] && modrm[5:3] == 3'b111) |=> !overflow_out);
endmodule

// File: tb/shift_rotate_unit_test.sv
`timescale 1ns/1ps
module shift_rotate_unit_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        in_valid = 0;
  logic [7:0]  opcode = 8'hD0, modrm = 8'hC0, imm_count = 0, cl_value = 0;
  logic [15:0] operand = 0;
  logic        carry_in = 0, of_in = 0;
  logic        out_valid;
  logic [15:0] result;
  logic        carry_out, overflow_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  shift_rotate_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .modrm(modrm),
    .imm_count(imm_count), .cl_value(cl_value), .operand(operand),
    .carry_in(carry_in), .of_in(of_in), .out_valid(out_valid), .result(result),
    .carry_out(carry_out), .overflow_out(overflow_out)
  );

  function automatic void model(
    input logic [7:0] op, input logic [7:0] mr, input logic [7:0] imm,
    input logic [7:0] cl, input logic [15:0] val, input logic cin, input logic oin,
    output logic [15:0] r, output logic c, output logic o);
    int w, n, k;
    longint unsigned mask, v, t, x;
    longint s;
    logic [2:0] sel;
    w    = op[0] ? 16 : 8;
    mask = (64'd1 << w) - 1;
    v    = longint'(val) & mask;
    n    = (op[4] ? (op[1] ? int'(cl) : 1) : int'(imm)) & 31;
    sel  = mr[5:3];
    if (n == 0) begin
      r = 16'(v); c = cin; o = oin; return;
    end
    case (sel)
      3'b000: begin k = n % w; t = ((v << k) | (v >> (w - k))) & mask; c = t[0]; end
      3'b001: begin k = n % w; t = ((v >> k) | (v << (w - k))) & mask; c = t[w-1]; end
      3'b010: begin
        x = (longint'(cin) << w) | v; k = n % (w + 1);
        x = ((x << k) | (x >> (w + 1 - k))) & ((mask << 1) | 1);
        t = x & mask; c = x[w];
      end
      3'b011: begin
        x = (longint'(cin) << w) | v; k = n % (w + 1);
        x = ((x >> k) | (x << (w + 1 - k))) & ((mask << 1) | 1);
        t = x & mask; c = x[w];
      end
      3'b100, 3'b110: begin x = v << n; t = x & mask; c = x[w]; end
      3'b101: begin x = (v << 1) >> n; t = (x >> 1) & mask; c = x[0]; end
      default: begin
        s = v[w-1] ? longint'(v | ~mask) : longint'(v);
        s = (s <<< 1) >>> n; t = longint'(s >>> 1) & mask; c = s[0];
      end
    endcase
    r = 16'(t);
    if (n != 1) o = oin;
    else case (sel)
      3'b001: o = t[w-1] ^ t[w-2];
      3'b011: o = v[w-1] ^ cin;
      3'b101: o = v[w-1];
      3'b111: o = 1'b0;
      default: o = t[w-1] ^ v[w-1];
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] op, input logic [7:0] mr,
                                   input logic [7:0] imm, input logic [7:0] cl);
    int n;
    n = (op[4] ? (op[1] ? int'(cl) : 1) : int'(imm)) & 31;
    if (n == 0) return "R6";
    case (mr[5:3])
      3'b110: return "R9";
      3'b111: return "R10";
      3'b100, 3'b101: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] op, input logic [7:0] mr, input logic [7:0] imm,
                     input logic [7:0] cl, input logic [15:0] val, input logic cin,
                     input logic oin, input string req);
    logic [15:0] er; logic ec, eo; int n; string t;
    model(op, mr, imm, cl, val, cin, oin, er, ec, eo);
    @(negedge clk);
    in_valid = 1; opcode = op; modrm = mr; imm_count = imm; cl_value = cl;
    operand = val; carry_in = cin; of_in = oin;
    @(negedge clk);
    in_valid = 0;
    t = (req != "") ? req : tag_of(op, mr, imm, cl);
    check({t, " valid"}, {31'd0, out_valid}, 32'd1);
    check({t, " result/cf"}, {15'd0, ec, result}, {15'd0, ec, er} ^ {15'd0, ec ^ carry_out, 16'd0});
    check({t, " result"}, {16'd0, result}, {16'd0, er});
    n = (op[4] ? (op[1] ? int'(cl) : 1) : int'(imm)) & 31;
    check((req != "") ? req : (n == 1 ? "R11" : (n == 0 ? "R6" : "R12")),
          {31'd0, overflow_out}, {31'd0, eo});
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] r_a, r_b; logic c_a, c_b;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 result", {16'd0, result}, 32'd0);
    check("R1 flags", {30'd0, carry_out, overflow_out}, 32'd0);
    rst = 0;
    @(negedge clk);
    // R2 idle gives no valid
    check("R2 idle", {31'd0, out_valid}, 32'd0);

    // R3 count source: imm=3, cl=5, fixed 1
    run(8'hC1, 8'hE0, 8'd3, 8'd5, 16'h0001, 0, 0, "");
    check("R3 imm", {16'd0, result}, 32'h0008);
    run(8'hD3, 8'hE0, 8'd3, 8'd5, 16'h0001, 0, 0, "");
    check("R3 cl", {16'd0, result}, 32'h0020);
    run(8'hD1, 8'hE0, 8'd3, 8'd5, 16'h0001, 0, 0, "");
    check("R3 one", {16'd0, result}, 32'h0002);
    // R4 byte mode ignores upper operand byte
    run(8'hD2, 8'hC8, 8'd0, 8'd4, 16'hA55A, 0, 0, "R4");
    check("R4 upper", {16'd0, result}, 32'h00A5);
    // R5 mod/rm bits ignored
    run(8'hD3, 8'h3D, 8'd0, 8'd7, 16'h8421, 1, 0, "R5");
    r_a = result; c_a = carry_out;
    run(8'hD3, 8'hFA, 8'd0, 8'd7, 16'h8421, 1, 0, "R5");
    r_b = result; c_b = carry_out;
    check("R5 ignore", {15'd0, c_a, r_a}, {15'd0, c_b, r_b});
    // R6 masking and zero count
    run(8'hC1, 8'hC0, 8'd32, 8'd0, 16'h1234, 1, 1, "R6");
    run(8'hC1, 8'hE8, 8'd33, 8'd0, 16'h8001, 0, 1, "");
    // R7 rotate-through-carry full cycle
    run(8'hC0, 8'hD0, 8'd9, 8'd0, 16'h005C, 1, 0, "R7");
    run(8'hC1, 8'hD8, 8'd17, 8'd0, 16'hBEEF, 0, 1, "R7");
    run(8'hC0, 8'hC0, 8'd8, 8'd0, 16'h0081, 0, 0, "R7");
    // R8 shift by exactly size and beyond
    run(8'hC0, 8'hE0, 8'd8, 8'd0, 16'h0001, 0, 0, "R8");
    run(8'hC1, 8'hE8, 8'd16, 8'd0, 16'h8000, 0, 0, "R8");
    run(8'hC1, 8'hE0, 8'd20, 8'd0, 16'hFFFF, 1, 0, "R8");
    // R9 alias
    run(8'hD1, 8'hF0, 8'd0, 8'd0, 16'h4001, 0, 0, "R9");
    r_a = result; c_a = carry_out;
    run(8'hD1, 8'hE0, 8'd0, 8'd0, 16'h4001, 0, 0, "R9");
    check("R9 alias", {14'd0, c_a, overflow_out, r_a}, {14'd0, carry_out, overflow_out, result});
    // R10 arithmetic right
    run(8'hC0, 8'hF8, 8'd12, 8'd0, 16'h0080, 0, 0, "R10");
    // R11 single-bit overflow per op
    for (int s = 0; s < 8; s++) begin
      run(8'hD1, {2'b11, 3'(s), 3'b000}, 8'd0, 8'd0, 16'hC000, 1, 0, "R11");
      run(8'hD0, {2'b11, 3'(s), 3'b000}, 8'd0, 8'd0, 16'h0040, 0, 1, "R11");
    end
    // R12 larger counts keep OF
    run(8'hD3, 8'hE0, 8'd0, 8'd2, 16'h4000, 0, 1, "R12");

    // constrained random sweep
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] op;
      logic c_bit, v_bit, w_bit;
      c_bit = 1'($urandom);
      v_bit = c_bit ? 1'($urandom) : 1'b0;
      w_bit = 1'($urandom);
      op = {3'b110, c_bit, 2'b00, v_bit, w_bit};
      run(op, 8'($urandom), ($urandom % 4 == 0) ? 8'($urandom % 40) : 8'($urandom),
          ($urandom % 2 == 0) ? 8'($urandom % 20) : 8'($urandom),
          16'($urandom), 1'($urandom), 1'($urandom), "");
    end

    @(negedge clk);
    check("R2 single pulse", {31'd0, out_valid}, 32'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule